// File: doc/BRIEF.md
# Cascaded LED Sink Chain Loader

This block sits on the host side of a chain of serial-in constant-current LED sink drivers. It accepts one frame of `DEV_COUNT × CH_PER_DEV` bits over a valid/ready handshake. It serialises the frame onto a data line and a serial clock, then raises a latch strobe so every driver copies its shift stage into its output stage. All of these wires are driven from one fast system clock. Every nanosecond limit of the driver is turned into a count of system-clock cycles at elaboration time. The formula rounds up, and no count is smaller than one cycle. The limits cover the data setup and hold, the clock high and low widths, the maximum serial rate, the gap from the last rising clock to the latch, the latch width and the enable width.

A separate blanking path drives the active-low output enable of the chain. It follows a level request, but never leaves either level sooner than the minimum enable width. It works independently of frame loading, so a frame can be shifted while the LEDs are dark.

Top module: `ledchain_loader`

## Requirements
- R1: `in_ready` is high only while no frame is in progress. A frame is taken on a rising `clk` edge where `in_valid` and `in_ready` are both high. While a frame is in progress, `in_valid` and `in_data` are ignored.
- R2: Bits leave the block most significant first, starting with `in_data[TOTAL-1]`. Bit `in_data[CH_PER_DEV*k + j]` ends in channel j of device k, where device 0 is the one wired nearest the block. Bit 0 is therefore the last bit shifted.
- R3: Each bit takes a low phase of LO cycles on `sclk` followed by a high phase of HI cycles. LO is the largest of the clock width, the setup time and the serial period minus HI. HI is the larger of the clock width and the hold time. With the defaults (125 MHz, 30 MHz limit), LO = 3 and HI = 2, so one bit takes 5 cycles. The first low phase starts in the cycle right after acceptance.
- R4: `sdi` changes only in the cycle where `sclk` falls or at frame acceptance. `sdi` never changes while `sclk` is high.
- R5: After the last high phase, `sclk` stays low for LSU cycles and then `le` is high for LEC cycles. With the defaults, LSU = 2 and LEC = 3. `sclk` is never high while `le` is high.
- R6: `frame_done` is high for exactly one cycle, right after `le` falls. `in_ready` returns in the following cycle.
- R7: `oe_n` follows `blank_req`, one cycle behind. Once `oe_n` changes level, it holds that level for at least OE cycles (OE = 9 by default), even if `blank_req` was only a one-cycle pulse.
- R8: In reset, `in_ready`=1, `sclk`=0, `sdi`=0, `le`=0, `frame_done`=0 and `oe_n`=1.
- R9: Blanking does not disturb a frame in progress. Shifting and latching proceed cycle for cycle whatever `blank_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| in_valid | input | 1 | frame offered |
| in_ready | output | 1 | block idle, frame can be taken |
| in_data | input | DEV_COUNT*CH_PER_DEV | frame bits, device k channel j at bit CH_PER_DEV*k+j |
| blank_req | input | 1 | level request to switch all LEDs off |
| sdi | output | 1 | serial data to the first driver |
| sclk | output | 1 | serial shift clock |
| le | output | 1 | latch strobe, active high |
| oe_n | output | 1 | output enable to the chain, active low |
| frame_done | output | 1 | one-cycle pulse after the latch |

## Verification
A change of the blanking request can land in the same cycle as frame acceptance, as a serial clock edge, or as the rising or falling edge of the latch strobe. The bench provokes this by toggling `blank_req` at fixed offsets inside a frame, including one-cycle pulses placed right at the latch. It judges the result by comparing every output against a cycle-by-cycle reference on every clock. A model of the driver chain, clocked on `sclk` and latched on `le`, must also hold the offered frame after each latch.

// File: rtl/ledc_pkg.sv
package ledc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SLO,
      ST_SHI,
      ST_LWAIT,
      ST_LPULSE,
      ST_DONE
   } ledc_state_e;

   // ceil(ns * MHz / 1000), never below one cycle
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
      int unsigned c;
      c = (ns * mhz + 999) / 1000;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ledc_serializer.sv
module ledc_serializer #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] load_data,
   input  logic             advance,
   output logic             sdi
);

   generate
      if (WIDTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst)       sdi <= 1'b0;
            else if (load) sdi <= load_data[0];
         end
      end else begin : g_multi
         logic [WIDTH-1:0] word_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               word_q <= '0;
               sdi    <= 1'b0;
            end else if (load) begin
               word_q <= load_data;
               sdi    <= load_data[WIDTH-1];
            end else if (advance) begin
               word_q <= {word_q[WIDTH-2:0], 1'b0};
               sdi    <= word_q[WIDTH-2];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ledc_frame_seq.sv
module ledc_frame_seq
   import ledc_pkg::*;
#(
   parameter int unsigned TOTAL   = 32,
   parameter int unsigned LO_CYC  = 3,
   parameter int unsigned HI_CYC  = 2,
   parameter int unsigned LSU_CYC = 2,
   parameter int unsigned LE_CYC  = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   output logic in_ready,
   output logic load,
   output logic advance,
   output logic sclk,
   output logic le,
   output logic frame_done
);

   localparam int unsigned MAXC = max2(max2(LO_CYC, HI_CYC), max2(LSU_CYC, LE_CYC));
   localparam int unsigned PH_W = $clog2(MAXC + 1);
   localparam int unsigned BL_W = $clog2(TOTAL + 1);

   ledc_state_e      st_q;
   logic [PH_W-1:0]  ph_q;
   logic [BL_W-1:0]  left_q;
   logic             ph_end;
   logic             last_bit;

   assign ph_end   = (ph_q == '0);
   assign last_bit = (left_q == BL_W'(1));
   assign in_ready = (st_q == ST_IDLE);
   assign load     = in_ready && in_valid;
   assign advance  = (st_q == ST_SHI) && ph_end && !last_bit;

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q       <= ST_IDLE;
         ph_q       <= '0;
         left_q     <= '0;
         sclk       <= 1'b0;
         le         <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               frame_done <= 1'b0;
               if (in_valid) begin
                  st_q   <= ST_SLO;
                  ph_q   <= PH_W'(LO_CYC - 1);
                  left_q <= BL_W'(TOTAL);
                  sclk   <= 1'b0;
               end
            end
            ST_SLO: begin
               if (ph_end) begin
                  st_q <= ST_SHI;
                  ph_q <= PH_W'(HI_CYC - 1);
                  sclk <= 1'b1;
               end else begin
                  ph_q <= ph_q - 1'b1;
               end
            end
            ST_SHI: begin
               if (ph_end) begin
                  sclk <= 1'b0;
                  if (last_bit) begin
                     st_q <= ST_LWAIT;
                     ph_q <= PH_W'(LSU_CYC - 1);
                  end else begin
                     st_q   <= ST_SLO;
                     ph_q   <= PH_W'(LO_CYC - 1);
                     left_q <= left_q - 1'b1;
                  end
               end else begin
                  ph_q <= ph_q - 1'b1;
               end
            end
            ST_LWAIT: begin
               if (ph_end) begin
                  st_q <= ST_LPULSE;
                  ph_q <= PH_W'(LE_CYC - 1);
                  le   <= 1'b1;
               end else begin
                  ph_q <= ph_q - 1'b1;
               end
            end
            ST_LPULSE: begin
               if (ph_end) begin
                  st_q       <= ST_DONE;
                  le         <= 1'b0;
                  frame_done <= 1'b1;
               end else begin
                  ph_q <= ph_q - 1'b1;
               end
            end
            default: begin
               st_q       <= ST_IDLE;
               frame_done <= 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/ledc_blank_gate.sv
module ledc_blank_gate #(
   parameter int unsigned OE_CYC = 9
) (
   input  logic clk,
   input  logic rst,
   input  logic blank_req,
   output logic oe_n
);

   localparam int unsigned HW = $clog2(OE_CYC + 1);

   logic [HW-1:0] hold_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_n   <= 1'b1;
         hold_q <= '0;
      end else if (hold_q != '0) begin
         hold_q <= hold_q - 1'b1;
      end else if (blank_req != oe_n) begin
         oe_n   <= blank_req;
         hold_q <= HW'(OE_CYC - 1);
      end
   end

endmodule

// File: rtl/ledchain_loader.sv
module ledchain_loader
   import ledc_pkg::*;
#(
   parameter int unsigned DEV_COUNT      = 2,
   parameter int unsigned CH_PER_DEV     = 16,
   parameter int unsigned SYS_MHZ        = 125,
   parameter int unsigned SCLK_MAX_MHZ   = 30,
   parameter int unsigned T_SETUP_NS     = 5,
   parameter int unsigned T_HOLD_NS      = 5,
   parameter int unsigned T_CLKW_NS      = 16,
   parameter int unsigned T_LATW_NS      = 20,
   parameter int unsigned T_LSU_NS       = 15,
   parameter int unsigned T_OEW_NS       = 70
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                in_valid,
   output logic                                in_ready,
   input  logic [DEV_COUNT*CH_PER_DEV-1:0]     in_data,
   input  logic                                blank_req,
   output logic                                sdi,
   output logic                                sclk,
   output logic                                le,
   output logic                                oe_n,
   output logic                                frame_done
);

   localparam int unsigned TOTAL   = DEV_COUNT * CH_PER_DEV;
   localparam int unsigned PER_CYC = (SYS_MHZ + SCLK_MAX_MHZ - 1) / SCLK_MAX_MHZ;
   localparam int unsigned HI_CYC  = max2(ns_to_cyc(T_CLKW_NS, SYS_MHZ), ns_to_cyc(T_HOLD_NS, SYS_MHZ));
   localparam int unsigned LO_MIN  = max2(ns_to_cyc(T_CLKW_NS, SYS_MHZ), ns_to_cyc(T_SETUP_NS, SYS_MHZ));
   localparam int unsigned LO_CYC  = (PER_CYC > HI_CYC) ? max2(LO_MIN, PER_CYC - HI_CYC) : LO_MIN;
   localparam int unsigned LSU_CYC = ns_to_cyc(T_LSU_NS, SYS_MHZ);
   localparam int unsigned LE_CYC  = ns_to_cyc(T_LATW_NS, SYS_MHZ);
   localparam int unsigned OE_CYC  = ns_to_cyc(T_OEW_NS, SYS_MHZ);

   generate
      if (DEV_COUNT < 1) begin : g_bad_dev
         $error("DEV_COUNT must be at least 1");
      end
      if (CH_PER_DEV < 1) begin : g_bad_ch
         $error("CH_PER_DEV must be at least 1");
      end
      if (SCLK_MAX_MHZ < 1 || SYS_MHZ < 1) begin : g_bad_clk
         $error("clock frequencies must be nonzero");
      end
   endgenerate

   logic load;
   logic advance;

   ledc_frame_seq #(
      .TOTAL  (TOTAL),
      .LO_CYC (LO_CYC),
      .HI_CYC (HI_CYC),
      .LSU_CYC(LSU_CYC),
      .LE_CYC (LE_CYC)
   ) u_seq (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .load      (load),
      .advance   (advance),
      .sclk      (sclk),
      .le        (le),
      .frame_done(frame_done)
   );

   ledc_serializer #(
      .WIDTH(TOTAL)
   ) u_ser (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_data(in_data),
      .advance  (advance),
      .sdi      (sdi)
   );

   ledc_blank_gate #(
      .OE_CYC(OE_CYC)
   ) u_blank (
      .clk      (clk),
      .rst      (rst),
      .blank_req(blank_req),
      .oe_n     (oe_n)
   );

endmodule

// File: rtl/ledchain_loader_chk.sv
module ledchain_loader_chk #(
   parameter int unsigned OE_CYC = 9
) (
   input logic clk,
   input logic rst,
   input logic in_ready,
   input logic sclk,
   input logic sdi,
   input logic le,
   input logic frame_done,
   input logic oe_n
);

   localparam int unsigned CW = $clog2(OE_CYC + 2);

   logic          oe_prev;
   logic [CW-1:0] oe_run;

   always_ff @(posedge clk) begin
      if (rst) begin
         oe_prev <= 1'b1;
         oe_run  <= CW'(OE_CYC);
      end else begin
         oe_prev <= oe_n;
         if (oe_n != oe_prev)          oe_run <= CW'(1);
         else if (oe_run < CW'(OE_CYC)) oe_run <= oe_run + 1'b1;
      end
   end

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      in_ready |-> (!sclk && !le));

   p_sdi_steady_high_r4: assert property (@(posedge clk) disable iff (rst)
      (sclk && $past(sclk)) |-> $stable(sdi));

   p_no_clk_in_latch_r5: assert property (@(posedge clk) disable iff (rst)
      le |-> !sclk);

   p_done_after_latch_r6: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> ($past(le) && !le && !in_ready));

   p_ready_after_done_r6: assert property (@(posedge clk) disable iff (rst)
      frame_done |=> in_ready);

   p_oe_min_width_r7: assert property (@(posedge clk) disable iff (rst)
      (oe_n != oe_prev) |-> (oe_run >= CW'(OE_CYC)));

endmodule

bind ledchain_loader ledchain_loader_chk #(.OE_CYC(OE_CYC)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_ready  (in_ready),
   .sclk      (sclk),
   .sdi       (sdi),
   .le        (le),
   .frame_done(frame_done),
   .oe_n      (oe_n)
);

// File: tb/ledchain_loader_test.sv
module ledchain_loader_test;

   localparam int TOTAL = 32;
   localparam int LO    = 3;
   localparam int HI    = 2;
   localparam int PER   = LO + HI;
   localparam int LSU   = 2;
   localparam int LEC   = 3;
   localparam int OE    = 9;
   localparam int ENDT  = TOTAL * PER + LSU + LEC + 1;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [TOTAL-1:0] in_data = '0;
   logic             blank_req = 1'b0;
   logic             sdi, sclk, le, oe_n, frame_done;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   ledchain_loader uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .blank_req(blank_req), .sdi(sdi), .sclk(sclk),
      .le(le), .oe_n(oe_n), .frame_done(frame_done)
   );

   // behavioural reference
   bit             m_busy = 0;
   int             m_t = 0;
   logic [TOTAL-1:0] m_data = '0;
   logic           m_oe = 1'b1;
   int             m_hold = 0;
   logic [TOTAL-1:0] frames_q[$];

   always @(posedge clk) begin
      if (rst) begin
         m_busy = 0; m_t = 0; m_oe = 1'b1; m_hold = 0;
      end else begin
         if (m_busy) begin
            if (m_t == ENDT) m_busy = 0;
            else m_t++;
         end else if (in_valid) begin
            m_busy = 1; m_t = 1; m_data = in_data;
            frames_q.push_back(in_data);
         end
         if (m_hold > 0) m_hold--;
         else if (blank_req != m_oe) begin
            m_oe = blank_req; m_hold = OE - 1;
         end
      end
   end

   // driver chain model
   logic [TOTAL-1:0] chain = '0;
   logic [TOTAL-1:0] latched = '0;
   always @(posedge sclk) chain = {chain[TOTAL-2:0], sdi};
   always @(posedge le) latched = chain;

   task automatic chk(input bit ok, input string tag, input logic [TOTAL-1:0] act,
                      input logic [TOTAL-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      logic e_sclk, e_le, e_done;
      e_sclk = 0; e_le = 0; e_done = 0;
      if (m_busy) begin
         if (m_t <= TOTAL * PER) e_sclk = (((m_t - 1) % PER) >= LO);
         e_le   = (m_t > TOTAL * PER + LSU) && (m_t <= TOTAL * PER + LSU + LEC);
         e_done = (m_t == ENDT);
      end
      chk(in_ready == !m_busy, "R1 ready", in_ready, !m_busy);
      chk(sclk == e_sclk, "R3 sclk", sclk, e_sclk);
      chk(le == e_le, "R5 le", le, e_le);
      chk(frame_done == e_done, "R6 frame_done", frame_done, e_done);
      chk(oe_n == m_oe, "R7 oe_n", oe_n, m_oe);
      if (rst) chk(sdi == 1'b0, "R8 sdi", sdi, 0);
      if (m_busy && m_t <= TOTAL * PER)
         chk(sdi == m_data[TOTAL - 1 - (m_t - 1) / PER], "R4 sdi", sdi,
             m_data[TOTAL - 1 - (m_t - 1) / PER]);
      if (!rst && frame_done) begin
         logic [TOTAL-1:0] exp_f;
         exp_f = frames_q.pop_front();
         chk(latched == exp_f, "R2 latched frame", latched, exp_f);
      end
   end

   task automatic send(input logic [TOTAL-1:0] d);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_data = d;
      @(negedge clk);
      in_valid = 1'b0; in_data = ~d;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (!in_ready) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #150000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R8 reset values
      chk(in_ready && !sclk && !le && !frame_done && oe_n, "R8 reset outputs",
          {in_ready, sclk, le, frame_done, oe_n}, 5'b10001);
      rst = 1'b0;
      repeat (12) @(negedge clk);
      send(32'h8000_0001);
      wait_idle();
      send(32'hA5C3_0FF0);
      wait_idle();
      // R1: valid held high across a frame; busy-time data ignored
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'h1234_5678;
      @(negedge clk);
      in_data = 32'hDEAD_BEEF;
      repeat (60) @(negedge clk);
      in_data = 32'h0F0F_F0F0;
      wait_idle();
      @(negedge clk);
      in_valid = 1'b0;
      wait_idle();
      // R7: one-cycle blank pulse while idle
      repeat (12) @(negedge clk);
      blank_req = 1'b1; @(negedge clk); blank_req = 1'b0;
      repeat (20) @(negedge clk);
      // R9: blanking during shift and around the latch
      fork
         send(32'hFFFF_0000);
         begin
            repeat (20) @(negedge clk);
            blank_req = 1'b1;
            repeat (3) @(negedge clk);
            blank_req = 1'b0;
            repeat (TOTAL * PER + LSU - 24) @(negedge clk);
            blank_req = 1'b1;
            @(negedge clk);
            blank_req = 1'b0;
         end
      join
      wait_idle();
      // rapid toggling and blank at acceptance
      fork
         send(32'h0000_FFFF);
         begin
            @(negedge clk);
            blank_req = 1'b1;
         end
      join
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         blank_req = ~blank_req;
      end
      blank_req = 1'b0;
      wait_idle();
      send(32'h0000_0000);
      wait_idle();
      repeat (20) @(negedge clk);
      finish_run();
   end

endmodule